// File: doc/BRIEF.md
# Trace Segment Fill Unit

This block builds trace segments out of the dynamic instruction stream and keeps the finished ones in a small trace store. Groups of up to four instruction records arrive through a valid/ready handshake. Each record carries a PC, a destination register, two source registers and a branch flag. The block merges each accepted group into the segment it is building. Because the records follow execution order, one segment can span several taken branches. A segment is closed when it is full, when a group would push it past the branch limit, or when a group would not fit in the slots that are left. A group that does not fit becomes the first group of the next segment.

Before a closed segment is stored, a marking pass looks at one slot per cycle. For each source operand it records which earlier slot in the segment produces that register. The input is held off while this pass runs. The segment is then written into a direct-mapped store, tagged with the PC of its first instruction. A separate lookup port takes a fetch address and returns, in the same cycle, a hit flag, the slot count and every valid slot together with its dependency tags.

Top module: `trace_fill_unit`

## Requirements
- R1: After reset, `in_ready` is 1, and every lookup misses with `lk_cnt` equal to 0.
- R2: Accepted groups are appended in arrival order, and within a group slot 0 comes first. The stored line is tagged with the full PC of the segment's first instruction. It sits at line index `pc[6:2]`, and slot 0 of a hit returns that PC.
- R3: A segment that reaches exactly 8 slots is closed on the cycle that accepts the group that fills it.
- R4: If a group would bring the number of branch-flagged slots in a non-empty segment above 3, the segment is closed without that group, and the group starts the next segment.
- R5: If a group would bring a non-empty segment above 8 slots, the segment is closed without that group, and the group starts the next segment.
- R6: For each source of slot s, the dependency tag is the highest slot index j < s whose destination equals that source. If there is none, the tag is 8. Slot 0 therefore always carries 8.
- R7: Dependency marking handles one slot per cycle. For a closed segment of n slots, `in_ready` stays 0 for exactly n+1 cycles after the closing acceptance edge. n cycles are spent marking and one cycle is spent storing.
- R8: A lookup is combinational on `lk_pc`. On a hit it returns the slot count and the fields of slots below that count. Slots at or above the count read as zero, and a miss reads as zero everywhere.
- R9: A lookup made during the cycle in which a line is being written sees the old contents of the store. The new line is visible from the next cycle on.
- R10: A stored segment whose start PC maps to an occupied line index replaces that line. Lookups of the earlier start PC then miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction group is offered |
| in_ready | output | 1 | Group is accepted on this edge when valid |
| in_cnt | input | 3 | Number of records in the group, 1 to 4 |
| in_pc | input | 128 | PC of each record, record i at bits [32i+31:32i] |
| in_dst | input | 20 | Destination register of each record, 5 bits each |
| in_src_a | input | 20 | First source register of each record |
| in_src_b | input | 20 | Second source register of each record |
| in_br | input | 4 | Branch flag of each record |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | A line tagged with `lk_pc` is stored |
| lk_cnt | output | 4 | Valid slot count of the hit line |
| lk_pcs | output | 256 | Slot PCs, 32 bits per slot |
| lk_dst | output | 40 | Slot destination registers |
| lk_src_a | output | 40 | Slot first source registers |
| lk_src_b | output | 40 | Slot second source registers |
| lk_br | output | 8 | Slot branch flags |
| lk_dep_a | output | 32 | Dependency tag of the first source, 4 bits per slot |
| lk_dep_b | output | 32 | Dependency tag of the second source, 4 bits per slot |

## Verification
The bench builds the block with its default values: 8 slots, 32 lines, groups of 4 and a branch limit of 3. With these values, a single run of eight groups reaches a full-segment close, a branch-limit close and a slot-overflow close. The 32-line index over `pc[6:2]` makes the start addresses 0x1000 and 0x3300 collide, so a later segment evicts an earlier one while the exact n+1 stall window and the write-then-visible timing are measured. A register pattern derived from each PC gives both matching and non-matching sources, which exercises the none tag and the latest-writer choice.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int PC_W  = 32;
    localparam int REG_W = 5;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic             is_br;
    } slot_t;

    typedef enum logic [1:0] {
        FILL_GATHER = 2'd0,
        FILL_MARK   = 2'd1,
        FILL_STORE  = 2'd2
    } fill_st_e;

endpackage

// File: rtl/tcf_dep_scan.sv
module tcf_dep_scan import tcf_pkg::*; #(
    parameter int SLOTS = 8,
    parameter int TAG_W = 4
) (
    input  logic [SLOTS-1:0][REG_W-1:0] dst_vec,
    input  logic [TAG_W-1:0]            pos,
    input  logic [REG_W-1:0]            src,
    output logic [TAG_W-1:0]            tag
);

    // latest earlier writer wins; SLOTS encodes "no producer"
    always_comb begin
        tag = TAG_W'(SLOTS);
        for (int j = 0; j < SLOTS; j++) begin
            if (j < int'(pos) && dst_vec[j] == src) begin
                tag = TAG_W'(j);
            end
        end
    end

endmodule

// File: rtl/tcf_collect.sv
module tcf_collect import tcf_pkg::*; #(
    parameter int SLOTS  = 8,
    parameter int GW     = 4,
    parameter int MAX_BR = 3,
    parameter int CNT_W  = 4,
    parameter int GC_W   = 3,
    parameter int TAG_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [GC_W-1:0]              in_cnt,
    input  slot_t [GW-1:0]               in_slots,
    output logic                         wr_en,
    output logic [PC_W-1:0]              wr_tag,
    output logic [CNT_W-1:0]             wr_cnt,
    output slot_t [SLOTS-1:0]            wr_slots,
    output logic [SLOTS-1:0][TAG_W-1:0]  wr_dep_a,
    output logic [SLOTS-1:0][TAG_W-1:0]  wr_dep_b
);

    localparam int IDX_W = $clog2(SLOTS);

    typedef struct packed {
        fill_st_e                   st;
        slot_t [SLOTS-1:0]          seg;
        logic [SLOTS-1:0][TAG_W-1:0] dep_a;
        logic [SLOTS-1:0][TAG_W-1:0] dep_b;
        logic [CNT_W-1:0]           n;
        logic [CNT_W-1:0]           nbr;
        logic [PC_W-1:0]            start;
        logic [TAG_W-1:0]           pos;
        logic                       pend;
        slot_t [GW-1:0]             pg;
        logic [GC_W-1:0]            pcnt;
    } fill_t;

    fill_t fill_d, fill_q;

    int                          g_br;
    int                          p_br;
    logic [CNT_W-1:0]            wi;
    logic [SLOTS-1:0][REG_W-1:0] dst_vec;
    slot_t                       cur;
    logic [1:0][TAG_W-1:0]       tag_k;
    logic [1:0][REG_W-1:0]       src_k;

    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            dst_vec[j] = fill_q.seg[j].dst;
        end
        cur      = fill_q.seg[fill_q.pos[IDX_W-1:0]];
        src_k[0] = cur.src_a;
        src_k[1] = cur.src_b;
    end

    for (genvar k = 0; k < 2; k++) begin : g_src
        tcf_dep_scan #(
            .SLOTS(SLOTS),
            .TAG_W(TAG_W)
        ) u_scan (
            .dst_vec(dst_vec),
            .pos    (fill_q.pos),
            .src    (src_k[k]),
            .tag    (tag_k[k])
        );
    end

    always_comb begin
        fill_d = fill_q;
        wi     = '0;
        g_br   = 0;
        p_br   = 0;
        for (int i = 0; i < GW; i++) begin
            if (i < int'(in_cnt)) g_br += int'(in_slots[i].is_br);
            if (i < int'(fill_q.pcnt)) p_br += int'(fill_q.pg[i].is_br);
        end

        case (fill_q.st)
            FILL_GATHER: begin
                if (in_valid && in_cnt != '0) begin
                    if (fill_q.n != '0 &&
                        (int'(fill_q.n) + int'(in_cnt) > SLOTS ||
                         int'(fill_q.nbr) + g_br > MAX_BR)) begin
                        // close without this group; it opens the next one
                        fill_d.st   = FILL_MARK;
                        fill_d.pos  = '0;
                        fill_d.pend = 1'b1;
                        fill_d.pg   = in_slots;
                        fill_d.pcnt = in_cnt;
                    end else begin
                        for (int i = 0; i < GW; i++) begin
                            wi = fill_q.n + CNT_W'(i);
                            if (i < int'(in_cnt) && int'(wi) < SLOTS) begin
                                fill_d.seg[wi[IDX_W-1:0]] = in_slots[i];
                            end
                        end
                        if (fill_q.n == '0) fill_d.start = in_slots[0].pc;
                        fill_d.n   = fill_q.n + CNT_W'(in_cnt);
                        fill_d.nbr = fill_q.nbr + CNT_W'(g_br);
                        if (int'(fill_q.n) + int'(in_cnt) == SLOTS) begin
                            fill_d.st  = FILL_MARK;
                            fill_d.pos = '0;
                        end
                    end
                end
            end
            FILL_MARK: begin
                fill_d.dep_a[fill_q.pos[IDX_W-1:0]] = tag_k[0];
                fill_d.dep_b[fill_q.pos[IDX_W-1:0]] = tag_k[1];
                if (int'(fill_q.pos) == int'(fill_q.n) - 1) begin
                    fill_d.st = FILL_STORE;
                end else begin
                    fill_d.pos = fill_q.pos + 1'b1;
                end
            end
            FILL_STORE: begin
                fill_d.st  = FILL_GATHER;
                fill_d.n   = '0;
                fill_d.nbr = '0;
                if (fill_q.pend) begin
                    fill_d.pend = 1'b0;
                    for (int i = 0; i < GW; i++) begin
                        if (i < int'(fill_q.pcnt) && i < SLOTS) fill_d.seg[i] = fill_q.pg[i];
                    end
                    fill_d.n     = CNT_W'(fill_q.pcnt);
                    fill_d.nbr   = CNT_W'(p_br);
                    fill_d.start = fill_q.pg[0].pc;
                end
            end
            default: fill_d.st = FILL_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q    <= '0;
            fill_q.st <= FILL_GATHER;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign in_ready = (fill_q.st == FILL_GATHER);
    assign wr_en    = (fill_q.st == FILL_STORE);
    assign wr_tag   = fill_q.start;
    assign wr_cnt   = fill_q.n;
    assign wr_slots = fill_q.seg;
    assign wr_dep_a = fill_q.dep_a;
    assign wr_dep_b = fill_q.dep_b;

endmodule

// File: rtl/tcf_store.sv
module tcf_store import tcf_pkg::*; #(
    parameter int SLOTS = 8,
    parameter int LINES = 32,
    parameter int CNT_W = 4,
    parameter int TAG_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PC_W-1:0]              wr_tag,
    input  logic [CNT_W-1:0]             wr_cnt,
    input  slot_t [SLOTS-1:0]            wr_slots,
    input  logic [SLOTS-1:0][TAG_W-1:0]  wr_dep_a,
    input  logic [SLOTS-1:0][TAG_W-1:0]  wr_dep_b,
    input  logic [PC_W-1:0]              lk_pc,
    output logic                         lk_hit,
    output logic [CNT_W-1:0]             lk_cnt,
    output slot_t [SLOTS-1:0]            lk_slots,
    output logic [SLOTS-1:0][TAG_W-1:0]  lk_dep_a,
    output logic [SLOTS-1:0][TAG_W-1:0]  lk_dep_b
);

    localparam int IX_W = $clog2(LINES);

    typedef struct packed {
        logic                        vld;
        logic [PC_W-1:0]             tag;
        logic [CNT_W-1:0]            cnt;
        slot_t [SLOTS-1:0]           s;
        logic [SLOTS-1:0][TAG_W-1:0] da;
        logic [SLOTS-1:0][TAG_W-1:0] db;
    } line_t;

    line_t [LINES-1:0] mem_d, mem_q;
    line_t             rd;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_tag[IX_W+1:2]].vld = 1'b1;
            mem_d[wr_tag[IX_W+1:2]].tag = wr_tag;
            mem_d[wr_tag[IX_W+1:2]].cnt = wr_cnt;
            mem_d[wr_tag[IX_W+1:2]].s   = wr_slots;
            mem_d[wr_tag[IX_W+1:2]].da  = wr_dep_a;
            mem_d[wr_tag[IX_W+1:2]].db  = wr_dep_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // read path works on registered contents only
    always_comb begin
        rd     = mem_q[lk_pc[IX_W+1:2]];
        lk_hit = rd.vld && (rd.tag == lk_pc);
        lk_cnt = lk_hit ? rd.cnt : '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (lk_hit && i < int'(rd.cnt)) begin
                lk_slots[i] = rd.s[i];
                lk_dep_a[i] = rd.da[i];
                lk_dep_b[i] = rd.db[i];
            end else begin
                lk_slots[i] = '0;
                lk_dep_a[i] = '0;
                lk_dep_b[i] = '0;
            end
        end
    end

endmodule

// File: rtl/trace_fill_unit.sv
module trace_fill_unit import tcf_pkg::*; #(
    parameter  int SLOTS  = 8,
    parameter  int LINES  = 32,
    parameter  int GW     = 4,
    parameter  int MAX_BR = 3,
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int GC_W   = $clog2(GW + 1),
    localparam int TAG_W  = $clog2(SLOTS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [GC_W-1:0]          in_cnt,
    input  logic [GW*PC_W-1:0]       in_pc,
    input  logic [GW*REG_W-1:0]      in_dst,
    input  logic [GW*REG_W-1:0]      in_src_a,
    input  logic [GW*REG_W-1:0]      in_src_b,
    input  logic [GW-1:0]            in_br,
    input  logic [PC_W-1:0]          lk_pc,
    output logic                     lk_hit,
    output logic [CNT_W-1:0]         lk_cnt,
    output logic [SLOTS*PC_W-1:0]    lk_pcs,
    output logic [SLOTS*REG_W-1:0]   lk_dst,
    output logic [SLOTS*REG_W-1:0]   lk_src_a,
    output logic [SLOTS*REG_W-1:0]   lk_src_b,
    output logic [SLOTS-1:0]         lk_br,
    output logic [SLOTS*TAG_W-1:0]   lk_dep_a,
    output logic [SLOTS*TAG_W-1:0]   lk_dep_b
);

    slot_t [GW-1:0]              grp;
    logic                        wr_en;
    logic [PC_W-1:0]             wr_tag;
    logic [CNT_W-1:0]            wr_cnt;
    slot_t [SLOTS-1:0]           wr_slots;
    logic [SLOTS-1:0][TAG_W-1:0] wr_dep_a, wr_dep_b;
    slot_t [SLOTS-1:0]           rd_slots;
    logic [SLOTS-1:0][TAG_W-1:0] rd_dep_a, rd_dep_b;

    always_comb begin
        for (int i = 0; i < GW; i++) begin
            grp[i].pc    = in_pc[i*PC_W +: PC_W];
            grp[i].dst   = in_dst[i*REG_W +: REG_W];
            grp[i].src_a = in_src_a[i*REG_W +: REG_W];
            grp[i].src_b = in_src_b[i*REG_W +: REG_W];
            grp[i].is_br = in_br[i];
        end
    end

    tcf_collect #(
        .SLOTS (SLOTS),
        .GW    (GW),
        .MAX_BR(MAX_BR),
        .CNT_W (CNT_W),
        .GC_W  (GC_W),
        .TAG_W (TAG_W)
    ) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .in_cnt  (in_cnt),
        .in_slots(grp),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_cnt  (wr_cnt),
        .wr_slots(wr_slots),
        .wr_dep_a(wr_dep_a),
        .wr_dep_b(wr_dep_b)
    );

    tcf_store #(
        .SLOTS(SLOTS),
        .LINES(LINES),
        .CNT_W(CNT_W),
        .TAG_W(TAG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_cnt  (wr_cnt),
        .wr_slots(wr_slots),
        .wr_dep_a(wr_dep_a),
        .wr_dep_b(wr_dep_b),
        .lk_pc   (lk_pc),
        .lk_hit  (lk_hit),
        .lk_cnt  (lk_cnt),
        .lk_slots(rd_slots),
        .lk_dep_a(rd_dep_a),
        .lk_dep_b(rd_dep_b)
    );

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            lk_pcs[i*PC_W +: PC_W]     = rd_slots[i].pc;
            lk_dst[i*REG_W +: REG_W]   = rd_slots[i].dst;
            lk_src_a[i*REG_W +: REG_W] = rd_slots[i].src_a;
            lk_src_b[i*REG_W +: REG_W] = rd_slots[i].src_b;
            lk_br[i]                   = rd_slots[i].is_br;
            lk_dep_a[i*TAG_W +: TAG_W] = rd_dep_a[i];
            lk_dep_b[i*TAG_W +: TAG_W] = rd_dep_b[i];
        end
    end

endmodule

// File: rtl/tcf_checker.sv
module tcf_checker import tcf_pkg::*; #(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4,
    parameter int TAG_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   wr_en,
    input logic [PC_W-1:0]        wr_tag,
    input logic [PC_W-1:0]        lk_pc,
    input logic                   lk_hit,
    input logic [CNT_W-1:0]       lk_cnt,
    input logic [SLOTS-1:0]       lk_br,
    input logic [PC_W-1:0]        lk_pc0,
    input logic [SLOTS*TAG_W-1:0] lk_dep_a,
    input logic [SLOTS*TAG_W-1:0] lk_dep_b
);

    a_r2_slot0_is_start: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pc0 == lk_pc);

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_cnt != '0 && int'(lk_cnt) <= SLOTS));

    a_r7_store_follows_mark: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(in_ready));

    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_cnt == '0 && lk_br == '0));

    a_r9_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lk_pc == wr_tag) |=> (lk_hit || lk_pc != $past(lk_pc)));

    for (genvar i = 0; i < SLOTS; i++) begin : g_dep
        a_r6_tag_points_back: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit && i < int'(lk_cnt)) |->
            ((lk_dep_a[i*TAG_W +: TAG_W] < TAG_W'(i) || lk_dep_a[i*TAG_W +: TAG_W] == TAG_W'(SLOTS)) &&
             (lk_dep_b[i*TAG_W +: TAG_W] < TAG_W'(i) || lk_dep_b[i*TAG_W +: TAG_W] == TAG_W'(SLOTS))));
    end

endmodule

bind trace_fill_unit tcf_checker #(
    .SLOTS(SLOTS),
    .CNT_W(CNT_W),
    .TAG_W(TAG_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_ready(in_ready),
    .wr_en   (wr_en),
    .wr_tag  (wr_tag),
    .lk_pc   (lk_pc),
    .lk_hit  (lk_hit),
    .lk_cnt  (lk_cnt),
    .lk_br   (lk_br),
    .lk_pc0  (lk_pcs[31:0]),
    .lk_dep_a(lk_dep_a),
    .lk_dep_b(lk_dep_b)
);

// File: tb/sim_trace_fill_unit.sv
`timescale 1ns/1ps
module sim_trace_fill_unit;

    localparam int S = 8;
    localparam int G = 4;
    localparam int NL = 32;
    localparam int NVEC = 8;

    // {count[2:0], start pc[31:0], branch mask[3:0], expected closed length[3:0]}
    localparam logic [42:0] VEC [NVEC] = '{
        {3'd4, 32'h0000_1000, 4'b0001, 4'd0},
        {3'd4, 32'h0000_2000, 4'b0000, 4'd8},
        {3'd3, 32'h0000_1040, 4'b0100, 4'd0},
        {3'd2, 32'h0000_3000, 4'b0011, 4'd0},
        {3'd1, 32'h0000_3104, 4'b0001, 4'd5},
        {3'd4, 32'h0000_3200, 4'b0000, 4'd0},
        {3'd4, 32'h0000_3300, 4'b0000, 4'd5},
        {3'd4, 32'h0000_1080, 4'b0000, 4'd8}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic in_ready;
    logic [2:0] in_cnt = '0;
    logic [G*32-1:0] in_pc = '0;
    logic [G*5-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [G-1:0] in_br = '0;
    logic [31:0] lk_pc = '0;
    logic lk_hit;
    logic [3:0] lk_cnt;
    logic [S*32-1:0] lk_pcs;
    logic [S*5-1:0] lk_dst, lk_src_a, lk_src_b;
    logic [S-1:0] lk_br;
    logic [S*4-1:0] lk_dep_a, lk_dep_b;

    always #2 clk = ~clk;

    trace_fill_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cnt(in_cnt), .in_pc(in_pc), .in_dst(in_dst), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_br(in_br), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_cnt(lk_cnt), .lk_pcs(lk_pcs), .lk_dst(lk_dst), .lk_src_a(lk_src_a),
        .lk_src_b(lk_src_b), .lk_br(lk_br), .lk_dep_a(lk_dep_a), .lk_dep_b(lk_dep_b)
    );

    int n_chk = 0;
    int n_fail = 0;

    // current group
    logic [31:0] g_pc [G];
    logic [4:0]  g_dst [G], g_sa [G], g_sb [G];
    logic        g_br [G];

    // model of the segment being built
    int          mn = 0, mnbr = 0;
    logic [31:0] mstart = '0;
    logic [31:0] ms_pc [S];
    logic [4:0]  ms_dst [S], ms_sa [S], ms_sb [S];
    logic        ms_br [S];

    // model of the store
    logic        ml_vld [NL];
    logic [31:0] ml_tag [NL];
    int          ml_cnt [NL];
    logic [31:0] ml_pc [NL][S];
    logic [4:0]  ml_dst [NL][S], ml_sa [NL][S], ml_sb [NL][S];
    logic        ml_br [NL][S];
    logic [3:0]  ml_da [NL][S], ml_db [NL][S];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic make_group(input int k, input logic [31:0] base, input logic [3:0] mask);
        for (int i = 0; i < G; i++) begin
            logic [31:0] p;
            int b;
            p = base + 32'(4 * i);
            b = int'((p >> 2) % 5);
            g_pc[i]  = (i < k) ? p : '0;
            g_dst[i] = (i < k) ? 5'(b) : '0;
            g_sa[i]  = (i < k) ? 5'((b + 2) % 5) : '0;
            g_sb[i]  = (i < k) ? 5'((b + 4) % 5) : '0;
            g_br[i]  = (i < k) ? mask[i] : 1'b0;
        end
    endtask

    task automatic m_close(output int len, output logic [31:0] spc);
        int ix;
        ix = int'((mstart >> 2) & 32'd31);
        ml_vld[ix] = 1'b1;
        ml_tag[ix] = mstart;
        ml_cnt[ix] = mn;
        for (int s = 0; s < S; s++) begin
            logic [3:0] da, db;
            ml_pc[ix][s]  = ms_pc[s];
            ml_dst[ix][s] = ms_dst[s];
            ml_sa[ix][s]  = ms_sa[s];
            ml_sb[ix][s]  = ms_sb[s];
            ml_br[ix][s]  = ms_br[s];
            da = 4'd8;
            db = 4'd8;
            for (int j = 0; j < s; j++) begin
                if (ms_dst[j] == ms_sa[s]) da = 4'(j);
                if (ms_dst[j] == ms_sb[s]) db = 4'(j);
            end
            ml_da[ix][s] = da;
            ml_db[ix][s] = db;
        end
        len = mn;
        spc = mstart;
        mn = 0;
        mnbr = 0;
    endtask

    task automatic m_push(input int k, output int fin, output logic [31:0] fpc);
        int gb;
        fin = 0;
        fpc = '0;
        gb = 0;
        for (int i = 0; i < k; i++) gb += int'(g_br[i]);
        if (mn > 0 && (mn + k > S || mnbr + gb > 3)) m_close(fin, fpc);
        if (mn == 0) mstart = g_pc[0];
        for (int i = 0; i < k; i++) begin
            ms_pc[mn]  = g_pc[i];
            ms_dst[mn] = g_dst[i];
            ms_sa[mn]  = g_sa[i];
            ms_sb[mn]  = g_sb[i];
            ms_br[mn]  = g_br[i];
            mn++;
        end
        mnbr += gb;
        if (mn == S) m_close(fin, fpc);
    endtask

    task automatic send(input int k);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!in_ready && guard < 100) begin
            guard++;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_cnt = 3'(k);
        for (int i = 0; i < G; i++) begin
            in_pc[i*32 +: 32]  = g_pc[i];
            in_dst[i*5 +: 5]   = g_dst[i];
            in_src_a[i*5 +: 5] = g_sa[i];
            in_src_b[i*5 +: 5] = g_sb[i];
            in_br[i]           = g_br[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_line(input logic [31:0] pc, input string req);
        int ix, ec;
        logic eh;
        lk_pc = pc;
        #1;
        ix = int'((pc >> 2) & 32'd31);
        eh = ml_vld[ix] && ml_tag[ix] == pc;
        ec = eh ? ml_cnt[ix] : 0;
        chk(req, $sformatf("hit @%0h", pc), lk_hit, eh);
        chk(req, $sformatf("count @%0h", pc), lk_cnt, ec);
        for (int s = 0; s < S; s++) begin
            logic on;
            on = eh && s < ec;
            chk(req, $sformatf("slot%0d pc", s), lk_pcs[s*32 +: 32], on ? ml_pc[ix][s] : 0);
            chk(req, $sformatf("slot%0d dst", s), lk_dst[s*5 +: 5], on ? ml_dst[ix][s] : 0);
            chk(req, $sformatf("slot%0d src_a", s), lk_src_a[s*5 +: 5], on ? ml_sa[ix][s] : 0);
            chk(req, $sformatf("slot%0d src_b", s), lk_src_b[s*5 +: 5], on ? ml_sb[ix][s] : 0);
            chk(req, $sformatf("slot%0d br", s), lk_br[s], on ? ml_br[ix][s] : 0);
            chk("R6", $sformatf("slot%0d dep_a", s), lk_dep_a[s*4 +: 4], on ? ml_da[ix][s] : 0);
            chk("R6", $sformatf("slot%0d dep_b", s), lk_dep_b[s*4 +: 4], on ? ml_db[ix][s] : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) ml_vld[i] = 1'b0;

        // reset state (R1)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "ready after reset", in_ready, 1);
        lk_pc = 32'h1000;
        #1;
        chk("R1", "lookup miss after reset", lk_hit, 0);
        chk("R1", "count zero after reset", lk_cnt, 0);

        // table walk: R2 merge, R3 full, R4 branch limit, R5 overflow, R7, R9
        for (int v = 0; v < NVEC; v++) begin
            int k, efin, fin, lowc, early;
            logic [31:0] fpc;
            k    = int'(VEC[v][42:40]);
            efin = int'(VEC[v][3:0]);
            make_group(k, VEC[v][39:8], VEC[v][7:4]);
            m_push(k, fin, fpc);
            send(k);
            if (efin != 0) begin
                lk_pc = fpc;
                #1;
                lowc = 0;
                early = 0;
                while (!in_ready && lowc < 100) begin
                    lowc++;
                    if (lk_hit) early++;
                    @(negedge clk);
                    #1;
                end
                chk("R7", $sformatf("stall cycles vec%0d", v), lowc, efin + 1);
                chk("R9", $sformatf("old contents during store vec%0d", v), early, 0);
                chk("R9", $sformatf("visible after store vec%0d", v), lk_hit, 1);
                chk("R3", $sformatf("closed length vec%0d", v), lk_cnt, efin);
            end
        end

        // R10: 0x1000 evicted by 0x3300 at line 0
        check_line(32'h1000, "R10");
        check_line(32'h3300, "R5");
        check_line(32'h3104, "R4");
        check_line(32'h5000, "R8");
        check_line(32'h1040, "R2");

        // hand-worked values for the segment at 0x1040
        chk("R4", "branch flags 0x1040", lk_br, 8'b0001_1100);
        chk("R6", "slot0 src_a none", lk_dep_a[3:0], 8);
        chk("R6", "slot1 src_b from slot0", lk_dep_b[7:4], 0);
        chk("R6", "slot4 src_b latest writer", lk_dep_b[19:16], 3);
        chk("R8", "slot5 reads zero", lk_pcs[5*32 +: 32], 0);
        lk_pc = 32'h3104;
        #1;
        chk("R4", "group after limit starts line", lk_pcs[31:0], 32'h3104);
        chk("R5", "overflowed segment count", lk_cnt, 5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule